// File: doc/BRIEF.md
# Programmable Pixel Clock Divider

This block makes a panel pixel clock from a fast system clock with an integer divider that software programs. The block runs entirely on one clock, `clk_i`, which is the double-rate source. The base source is modelled as an enable that is active on every second `clk_i` cycle. A source-select bit picks which of the two rates advances the divider.

A launch-edge bit chooses the pixel clock edge on which downstream pixel data changes. The block marks that edge with a one-cycle clock-enable strobe, `pix_ce_o`, so that downstream logic can stay on `clk_i`.

Software writes all settings through one bit-masked configuration word. The divider ratio, source and launch edge are staged and are applied only at the end of a pixel clock period. An enable sequencer gates the whole output through `gate_i`.

Top module: `pixclk_divider`

## Requirements
- R1: After reset, `pix_clk_o` and `pix_ce_o` are low. The staged settings are ratio 0 (treated as 2), base source and rising launch edge.
- R2: While `gate_i` is low, `pix_clk_o` and `pix_ce_o` are low from the cycle after `gate_i` is sampled low. When `gate_i` is sampled high, the first period starts with the high phase:
  - with the fast source, the high phase starts on the next cycle;
  - with the base source, it starts one cycle later.
- R3: With the fast source and ratio N, the pixel clock period is N `clk_i` cycles. The high phase lasts floor(N/2) cycles and the low phase lasts the remainder.
- R4: A programmed ratio of 0 or 1 behaves as ratio 2.
- R5: The ratio request field is bits [15:0] of the configuration word and is 16 bits wide. A request above the divider maximum (255 with the default 8-bit divider) is stored as 255.
- R6: Bit 16 of the configuration word selects the source (1 = fast, 0 = base). With the base source, each phase lasts twice as many `clk_i` cycles as in R3.
- R7: Bit 17 of the configuration word selects the launch edge. When it is 0, `pix_ce_o` is high in the first cycle of each high phase. When it is 1, `pix_ce_o` is high in the first cycle of each low phase.
- R8: A write changes only the bits whose mask bit (`cfg_wmask_i`) is 1. Fields that are masked off keep their value.
- R9: Settings written while the clock runs take effect only at the next period boundary. The period in progress finishes with the old ratio.
- R10: `pix_ce_o` is asserted for exactly one cycle per pixel clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_wmask_i | input | 32 | Per-bit write mask |
| gate_i | input | 1 | Pixel clock gate from the enable sequencer |
| pix_clk_o | output | 1 | Divided pixel clock |
| pix_ce_o | output | 1 | One-cycle strobe on the launch edge |

## Verification
The hardest situation to create is a settings change that arrives in the middle of a running period. The bench has to show that the period in progress ends with the old low-phase length and that only the following period uses the new ratio.

To set this up, the bench waits for the launch strobe of a period with a short ratio. While that high phase is still running, it writes a much larger ratio. It then counts the remaining low phase and the next full period separately.

A masked write that leaves the ratio and source unchanged while changing only the launch edge is checked in the same way.

// File: rtl/pixclk_pkg.sv
package pixclk_pkg;

    // Configuration word layout
    localparam int CFG_W    = 32;
    localparam int REQ_LSB  = 0;
    localparam int REQ_W    = 16;
    localparam int SRC_BIT  = 16;
    localparam int EDGE_BIT = 17;

    typedef enum logic {
        SRC_BASE = 1'b0,
        SRC_FAST = 1'b1
    } src_e;

    typedef enum logic {
        LAUNCH_RISE = 1'b0,
        LAUNCH_FALL = 1'b1
    } launch_e;

endpackage

// File: rtl/pixclk_cfg_reg.sv
module pixclk_cfg_reg
    import pixclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] wdata_i,
    input  logic [CFG_W-1:0] wmask_i,
    output logic [DIV_W-1:0] div_o,
    output src_e             src_o,
    output launch_e          launch_o
);

    localparam logic [REQ_W-1:0] DIV_MAX = {{(REQ_W-DIV_W){1'b0}}, {DIV_W{1'b1}}};

    typedef struct packed {
        logic [DIV_W-1:0] div;
        src_e             src;
        launch_e          launch;
    } cfg_st_t;

    cfg_st_t          st_d, st_q;
    logic [REQ_W-1:0] req_old, req_new;
    logic             unused_hi;

    assign unused_hi = ^{wdata_i[CFG_W-1:EDGE_BIT+1], wmask_i[CFG_W-1:EDGE_BIT+1]};

    always_comb begin
        st_d    = st_q;
        req_old = {{(REQ_W-DIV_W){1'b0}}, st_q.div};
        req_new = (req_old & ~wmask_i[REQ_LSB +: REQ_W])
                | (wdata_i[REQ_LSB +: REQ_W] & wmask_i[REQ_LSB +: REQ_W]);
        if (wr_i) begin
            if (req_new > DIV_MAX) begin
                st_d.div = {DIV_W{1'b1}};
            end else begin
                st_d.div = req_new[DIV_W-1:0];
            end
            if (wmask_i[SRC_BIT]) begin
                st_d.src = src_e'(wdata_i[SRC_BIT]);
            end
            if (wmask_i[EDGE_BIT]) begin
                st_d.launch = launch_e'(wdata_i[EDGE_BIT]);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{div: '0, src: SRC_BASE, launch: LAUNCH_RISE};
        end else begin
            st_q <= st_d;
        end
    end

    assign div_o    = st_q.div;
    assign src_o    = st_q.src;
    assign launch_o = st_q.launch;

    // R5: an oversized request lands on the all-ones divider value
    assert_saturate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && (&wmask_i[REQ_LSB +: REQ_W]) && (wdata_i[REQ_LSB +: REQ_W] > DIV_MAX))
        |=> (&div_o));

    // R8: masked-off fields keep their value
    assert_masked_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !wmask_i[SRC_BIT] && !wmask_i[EDGE_BIT])
        |=> ($stable(src_o) && $stable(launch_o)));

endmodule

// File: rtl/pixclk_tick_gen.sv
module pixclk_tick_gen (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic fast_i,
    output logic tick_o
);

    typedef struct packed {
        logic phase;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.phase = 1'b0;
        end else begin
            st_d.phase = ~st_q.phase;
        end
        tick_o = run_i && (fast_i || st_q.phase);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // R6: the base source never advances on two cycles in a row
    assert_base_half_rate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && !fast_i) |=> (!tick_o || fast_i));

endmodule

// File: rtl/pixclk_div_core.sv
module pixclk_div_core
    import pixclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             gate_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    input  src_e             src_i,
    input  launch_e          launch_i,
    output logic             fast_o,
    output logic             pix_clk_o,
    output logic             pix_ce_o
);

    localparam logic [DIV_W-1:0] RATIO_MIN = DIV_W'(2);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] ratio;
        src_e             src;
        launch_e          launch;
        logic             pclk;
        logic             ce;
    } core_st_t;

    core_st_t         st_d, st_q;
    logic [DIV_W-1:0] ratio_new;
    logic [DIV_W-1:0] half;
    logic             last;

    always_comb begin
        ratio_new = (div_i < RATIO_MIN) ? RATIO_MIN : div_i;
        half      = st_q.ratio >> 1;
        last      = (st_q.cnt == st_q.ratio - DIV_W'(1));
        st_d      = st_q;
        st_d.ce   = 1'b0;
        if (!gate_i) begin
            st_d.cnt    = '0;
            st_d.pclk   = 1'b0;
            st_d.ratio  = ratio_new;
            st_d.src    = src_i;
            st_d.launch = launch_i;
        end else if (tick_i) begin
            st_d.pclk = (st_q.cnt < half);
            st_d.ce   = (st_q.launch == LAUNCH_FALL) ? (st_q.cnt == half)
                                                     : (st_q.cnt == '0);
            if (last) begin
                st_d.cnt    = '0;
                st_d.ratio  = ratio_new;
                st_d.src    = src_i;
                st_d.launch = launch_i;
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0, ratio: RATIO_MIN, src: SRC_BASE,
                      launch: LAUNCH_RISE, pclk: 1'b0, ce: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fast_o    = (st_q.src == SRC_FAST);
    assign pix_clk_o = st_q.pclk;
    assign pix_ce_o  = st_q.ce;

    // R4: the active ratio never drops below two
    assert_ratio_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ratio >= RATIO_MIN);

    // R2: a low gate forces both outputs low on the next cycle
    assert_gate_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gate_i |=> (!pix_clk_o && !pix_ce_o));

    // R9: the active ratio changes only at a period boundary
    assert_boundary_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(st_q.ratio) |-> (st_q.cnt == '0));

    // R7: the strobe always sits on a pixel clock transition
    assert_strobe_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pix_ce_o |-> ($rose(pix_clk_o) || $fell(pix_clk_o)));

endmodule

// File: rtl/pixclk_divider.sv
module pixclk_divider
    import pixclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  logic [CFG_W-1:0] cfg_wmask_i,
    input  logic             gate_i,
    output logic             pix_clk_o,
    output logic             pix_ce_o
);

    logic [DIV_W-1:0] div_sh;
    src_e             src_sh;
    launch_e          launch_sh;
    logic             fast_act;
    logic             tick;

    pixclk_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (cfg_wr_i),
        .wdata_i  (cfg_wdata_i),
        .wmask_i  (cfg_wmask_i),
        .div_o    (div_sh),
        .src_o    (src_sh),
        .launch_o (launch_sh)
    );

    pixclk_tick_gen u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (gate_i),
        .fast_i (fast_act),
        .tick_o (tick)
    );

    pixclk_div_core #(.DIV_W(DIV_W)) u_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .gate_i    (gate_i),
        .tick_i    (tick),
        .div_i     (div_sh),
        .src_i     (src_sh),
        .launch_i  (launch_sh),
        .fast_o    (fast_act),
        .pix_clk_o (pix_clk_o),
        .pix_ce_o  (pix_ce_o)
    );

    // R10: the strobe is a single-cycle pulse
    assert_single_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pix_ce_o |=> !pix_ce_o);

endmodule

// File: tb/pixclk_divider_tb.sv
module pixclk_divider_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] wmask = '0;
    logic        gate = 1'b0;
    logic        pix_clk;
    logic        pix_ce;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pixclk_divider u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_wr_i    (wr),
        .cfg_wdata_i (wdata),
        .cfg_wmask_i (wmask),
        .gate_i      (gate),
        .pix_clk_o   (pix_clk),
        .pix_ce_o    (pix_ce)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [31:0] d, logic [31:0] m);
        wr = 1'b1; wdata = d; wmask = m;
        @(negedge clk);
        wr = 1'b0; wdata = '0; wmask = '0;
    endtask

    function automatic logic [31:0] word(int ratio, bit fast, bit fall);
        return 32'(ratio & 16'hFFFF) | (32'(fast) << 16) | (32'(fall) << 17);
    endfunction

    task automatic run_cfg(int ratio, bit fast, bit fall);
        gate = 1'b0;
        @(negedge clk);
        cfg_write(word(ratio, fast, fall), 32'h0003_FFFF);
        @(negedge clk);
        gate = 1'b1;
    endtask

    // Measures one full period starting at a rising edge
    task automatic measure(output int hi, output int lo, output int ce_hi,
                           output int ce_lo, output int ce_n);
        int guard;
        hi = 0; lo = 0; ce_hi = 0; ce_lo = 0; ce_n = 0;
        guard = 0;
        @(negedge clk);
        while (pix_clk !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
        while (pix_clk !== 1'b1 && guard < 4000) begin @(negedge clk); guard++; end
        ce_hi = int'(pix_ce);
        while (pix_clk === 1'b1 && guard < 4000) begin
            hi++; ce_n += int'(pix_ce); @(negedge clk); guard++;
        end
        ce_lo = int'(pix_ce);
        while (pix_clk === 1'b0 && guard < 4000) begin
            lo++; ce_n += int'(pix_ce); @(negedge clk); guard++;
        end
        if (guard >= 4000) chk("timeout", guard, 0);
    endtask

    task automatic period_chk(string req, int ehi, int elo, bit fall);
        int hi, lo, ch, cl, cn;
        measure(hi, lo, ch, cl, cn);
        measure(hi, lo, ch, cl, cn);
        chk({req, " high"}, hi, ehi);
        chk({req, " low"}, lo, elo);
        chk({req, " R7 ce at rise"}, ch, fall ? 0 : 1);
        chk({req, " R7 ce at fall"}, cl, fall ? 1 : 0);
        chk({req, " R10 ce count"}, cn, 1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 clk reset", int'(pix_clk), 0);
        chk("R1 ce reset", int'(pix_ce), 0);
    endtask

    task automatic t_default;
        // R1: reset settings act as ratio 2 on the base source
        gate = 1'b1;
        period_chk("R1 default", 2, 2, 1'b0);
    endtask

    task automatic t_gate;
        int seen;
        run_cfg(4, 1'b1, 1'b0);
        repeat (10) @(negedge clk);
        gate = 1'b0;
        seen = 0;
        repeat (20) begin
            @(negedge clk);
            seen += int'(pix_clk) + int'(pix_ce);
        end
        chk("R2 held low", seen, 0);
        gate = 1'b1;
        @(negedge clk);
        chk("R2 restart fast clk", int'(pix_clk), 1);
        chk("R2 restart fast ce", int'(pix_ce), 1);
    endtask

    task automatic t_fast;
        run_cfg(4, 1'b1, 1'b0);
        period_chk("R3 even", 2, 2, 1'b0);
        run_cfg(5, 1'b1, 1'b0);
        period_chk("R3 odd", 2, 3, 1'b0);
    endtask

    task automatic t_slow;
        run_cfg(3, 1'b0, 1'b0);
        @(negedge clk);
        chk("R2 R6 slow first cycle", int'(pix_clk), 0);
        @(negedge clk);
        chk("R2 R6 slow second cycle", int'(pix_clk), 1);
        period_chk("R6 slow", 2, 4, 1'b0);
    endtask

    task automatic t_clamp;
        run_cfg(0, 1'b1, 1'b0);
        period_chk("R4 zero", 1, 1, 1'b0);
        run_cfg(1, 1'b1, 1'b0);
        period_chk("R4 one", 1, 1, 1'b0);
    endtask

    task automatic t_saturate;
        run_cfg(300, 1'b1, 1'b0);
        period_chk("R5 300", 127, 128, 1'b0);
        run_cfg(16'hFFFF, 1'b1, 1'b0);
        period_chk("R5 max", 127, 128, 1'b0);
    endtask

    task automatic t_fall;
        run_cfg(7, 1'b1, 1'b1);
        period_chk("R7 fall", 3, 4, 1'b1);
    endtask

    task automatic t_masked;
        run_cfg(6, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        // only the launch-edge bit is enabled; ratio and source bits carry junk
        cfg_write(32'h0002_0003, 32'h0002_0000);
        period_chk("R8 masked", 3, 3, 1'b1);
    endtask

    task automatic t_boundary;
        int hi, lo, guard;
        run_cfg(4, 1'b1, 1'b0);
        repeat (6) @(negedge clk);
        guard = 0;
        while (!(pix_ce === 1'b1) && guard < 100) begin @(negedge clk); guard++; end
        cfg_write(word(10, 1'b1, 1'b0), 32'h0003_FFFF);
        while (pix_clk === 1'b1 && guard < 200) begin @(negedge clk); guard++; end
        lo = 0;
        while (pix_clk === 1'b0 && guard < 200) begin lo++; @(negedge clk); guard++; end
        chk("R9 old low phase", lo, 2);
        hi = 0;
        while (pix_clk === 1'b1 && guard < 200) begin hi++; @(negedge clk); guard++; end
        chk("R9 new high phase", hi, 5);
        lo = 0;
        while (pix_clk === 1'b0 && guard < 200) begin lo++; @(negedge clk); guard++; end
        chk("R9 new low phase", lo, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default();
        t_gate();
        t_fast();
        t_slow();
        t_clamp();
        t_saturate();
        t_fall();
        t_masked();
        t_boundary();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule